// File: doc/BRIEF.md
# Overlapping-Word Memory Checksum Engine

This block computes a 16-bit checksum over a byte-addressed memory region and stores the result back into that memory. A caller presents a start address, a byte count and a destination address, and pulses `go`. The engine reads the region through a synchronous single-byte read port and folds successive big-endian 16-bit words into the checksum. Each word starts one byte after the previous one, so neighbouring words share a byte. It then writes the two result bytes to the destination and pulses `done`.

The fold step is nibble-based, not a shift-register polynomial. It works on the low byte of the exclusive-or of the running value and the word. A region with an odd length ends with one extra step, which uses the last byte as a high byte padded with zero. A typical use covers a 248-byte header that starts at address 0 and places the checksum at byte addresses 0xFC and 0xFD.

Top module: `nvram_csum_engine`

## Requirements
- R1: After reset `busy`, `done`, `rd_en` and `wr_en` are low and `csum` reads 0xFFFF.
- R2: The running value starts at 0xFFFF. For a word v and previous value p, let d = p^v, a = d[3:0] and b = d[7:4]^a. The next value is (p>>8) ^ (a<<3) ^ (a<<8) ^ b ^ (b<<7) ^ (b<<12), truncated to 16 bits.
- R3: Let E be the count rounded down to even. For i = 0 to E-1, step i folds the word whose high byte is at start+i and whose low byte is at start+i+1.
- R4: If the count is odd, one last step folds the word {byte at start+E, 8'h00}.
- R5: A zero count performs no reads and writes back 0xFFFF.
- R6: Read data is taken one cycle after `rd_en`. Reads never occur in back-to-back cycles. Addresses rise by one from `start_addr`: cnt+1 bytes are read for an even nonzero count and cnt bytes for an odd count.
- R7: The write-back puts `csum[15:8]` at `dest_addr` and `csum[7:0]` at `dest_addr+1` in two consecutive cycles. `done` is high for exactly the one cycle after the second write.
- R8: `go` is ignored while `busy` is high. A run starts only from a `go` seen while idle.
- R9: `rd_en` and `wr_en` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| go | input | 1 | Start strobe, sampled only when idle |
| start_addr | input | AW | First byte of the region |
| byte_cnt | input | CW | Number of bytes covered |
| dest_addr | input | AW | Address for the high result byte |
| rd_en | output | 1 | Read strobe |
| rd_addr | output | AW | Read address |
| rd_data | input | 8 | Read data, valid the cycle after `rd_en` |
| wr_en | output | 1 | Write strobe |
| wr_addr | output | AW | Write address |
| wr_data | output | 8 | Write data |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |
| csum | output | 16 | Running and final checksum |

## Verification
The bench builds the engine with AW = 9 and CW = 9 and attaches a 512-byte memory model. This size holds a full 248-byte header run at address 0 with its result at 0xFC, together with separate regions and destinations above 0x100. With these widths the run lengths stay short, while odd, even, single-byte and zero counts all remain reachable. A `go` that arrives during a run is checked by giving it different operands and a guarded destination whose contents must survive.

// File: rtl/nvram_csum_engine.sv
module nvram_csum_engine #(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [AW-1:0] start_addr,
  input  logic [CW-1:0] byte_cnt,
  input  logic [AW-1:0] dest_addr,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  input  logic [7:0]    rd_data,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic          busy,
  output logic          done,
  output logic [15:0]   csum
);

  typedef enum logic [2:0] {
    S_IDLE, S_PRIME, S_LATCH, S_FETCH, S_STEP, S_TAIL, S_WRH, S_WRL
  } st_t;

  localparam logic [15:0] SEED = 16'hFFFF;

  st_t           st;
  logic          fin;
  logic          odd;
  logic [7:0]    hold;
  logic [AW-1:0] ptr;
  logic [AW-1:0] dst;
  logic [CW-1:0] left;
  logic [CW-1:0] even_cnt;

  function automatic logic [15:0] fold(input logic [15:0] p, input logic [15:0] v);
    logic [15:0] d, a, b;
    d = p ^ v;
    a = {12'd0, d[3:0]};
    b = {12'd0, d[7:4]} ^ a;
    return (p >> 8) ^ (a << 3) ^ (a << 8) ^ b ^ (b << 7) ^ (b << 12);
  endfunction

  assign even_cnt = {byte_cnt[CW-1:1], 1'b0};
  assign busy     = (st != S_IDLE) || fin;
  assign done     = fin;
  assign rd_en    = (st == S_PRIME) || (st == S_FETCH);
  assign rd_addr  = ptr;
  assign wr_en    = (st == S_WRH) || (st == S_WRL);
  assign wr_addr  = (st == S_WRL) ? dst + AW'(1) : dst;
  assign wr_data  = (st == S_WRL) ? csum[7:0] : csum[15:8];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      fin  <= 1'b0;
      odd  <= 1'b0;
      hold <= '0;
      ptr  <= '0;
      dst  <= '0;
      left <= '0;
      csum <= SEED;
    end else begin
      fin <= 1'b0;
      unique case (st)
        S_IDLE: if (go && !fin) begin
          csum <= SEED;
          ptr  <= start_addr;
          dst  <= dest_addr;
          left <= even_cnt;
          odd  <= byte_cnt[0];
          st   <= (byte_cnt == '0) ? S_WRH : S_PRIME;
        end
        S_PRIME: st <= S_LATCH;
        S_LATCH: begin
          hold <= rd_data;
          ptr  <= ptr + AW'(1);
          st   <= (left == '0) ? S_TAIL : S_FETCH;
        end
        S_FETCH: st <= S_STEP;
        S_STEP: begin
          csum <= fold(csum, {hold, rd_data});
          hold <= rd_data;
          ptr  <= ptr + AW'(1);
          left <= left - CW'(1);
          if (left == CW'(1)) st <= odd ? S_TAIL : S_WRH;
          else                st <= S_FETCH;
        end
        S_TAIL: begin
          csum <= fold(csum, {hold, 8'h00});
          st   <= S_WRH;
        end
        S_WRH: st <= S_WRL;
        S_WRL: begin
          fin <= 1'b1;
          st  <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/nvram_csum_engine_chk.sv
module nvram_csum_engine_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          go,
  input logic          busy,
  input logic          done,
  input logic          rd_en,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr
);

  assert_no_rd_wr_overlap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && wr_en));

  assert_reads_spaced_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> !rd_en);

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_low_byte_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_en) |=> (wr_en && wr_addr == $past(wr_addr) + AW'(1)));

  assert_done_after_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wr_en) |-> done);

  assert_start_needs_go_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(go));

endmodule

bind nvram_csum_engine nvram_csum_engine_chk #(.AW(AW)) i_chk (
  .clk(clk), .rst_n(rst_n), .go(go), .busy(busy), .done(done),
  .rd_en(rd_en), .wr_en(wr_en), .wr_addr(wr_addr)
);

// File: tb/test_nvram_csum_engine.sv
module test_nvram_csum_engine;
  localparam int AW = 9;
  localparam int CW = 9;
  localparam int MS = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          go = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic [CW-1:0] byte_cnt = '0;
  logic [AW-1:0] dest_addr = '0;
  logic          rd_en, wr_en, busy, done;
  logic [AW-1:0] rd_addr, wr_addr;
  logic [7:0]    rd_data, wr_data;
  logic [15:0]   csum;

  logic [7:0]    mem [MS];
  logic [7:0]    rdq = '0;
  int            nvec = 0, nbad = 0, cycles = 0;
  int            rd_count = 0, rd_misorder = 0;
  logic [AW-1:0] rd_expect = '0;

  always #5 clk = ~clk;

  nvram_csum_engine #(.AW(AW), .CW(CW)) i_nvram_csum_engine (
    .clk(clk), .rst_n(rst_n), .go(go), .start_addr(start_addr),
    .byte_cnt(byte_cnt), .dest_addr(dest_addr), .rd_en(rd_en),
    .rd_addr(rd_addr), .rd_data(rd_data), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .busy(busy), .done(done), .csum(csum)
  );

  assign rd_data = rdq;

  always @(posedge clk) begin
    if (rd_en) begin
      rdq <= mem[rd_addr];
      if (rd_addr !== rd_expect) rd_misorder <= rd_misorder + 1;
      rd_expect <= rd_expect + AW'(1);
      rd_count  <= rd_count + 1;
    end
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_step(input logic [15:0] p, input logic [15:0] v);
    logic [15:0] d, t, a, b, r;
    d = p ^ v;
    t = {8'h00, p[15:8]};
    a = {12'h000, d[3:0]};
    b = {12'h000, d[7:4] ^ d[3:0]};
    r = t ^ {a[12:0], 3'b000} ^ {a[7:0], 8'h00} ^ b ^ {b[8:0], 7'd0} ^ {b[3:0], 12'h000};
    return r;
  endfunction

  function automatic logic [15:0] ref_sum(input int s, input int n);
    logic [15:0] c = 16'hFFFF;
    int e = n & ~1;
    for (int i = 0; i < e; i++)
      c = ref_step(c, {mem[(s+i) % MS], mem[(s+i+1) % MS]});
    if (n % 2 == 1) c = ref_step(c, {mem[(s+e) % MS], 8'h00});
    return c;
  endfunction

  task automatic wait_done(output bit ok);
    ok = 0;
    for (int k = 0; k < 5000; k++) begin
      @(negedge clk);
      if (done) begin ok = 1; break; end
    end
  endtask

  task automatic launch(input int s, input int n, input int d);
    @(negedge clk);
    start_addr = AW'(s); byte_cnt = CW'(n); dest_addr = AW'(d);
    rd_count = 0; rd_misorder = 0; rd_expect = AW'(s);
    go = 1'b1;
    @(negedge clk);
    go = 1'b0;
  endtask

  task automatic run_check(input string req, input int s, input int n, input int d);
    logic [15:0] exp;
    bit ok;
    int exp_reads;
    exp = ref_sum(s, n);
    exp_reads = (n == 0) ? 0 : ((n % 2 == 1) ? n : n + 1);
    launch(s, n, d);
    wait_done(ok);
    chk(req, "completion", ok, 1);
    chk(req, "csum", csum, exp);
    chk("R7", "high byte at dest", mem[d % MS], exp[15:8]);
    chk("R7", "low byte at dest+1", mem[(d+1) % MS], exp[7:0]);
    chk("R6", "read count", rd_count, exp_reads);
    chk("R6", "read order", rd_misorder, 0);
    @(negedge clk);
    chk("R7", "done one cycle", done, 0);
  endtask

  task automatic t_reset;
    chk("R1", "busy", busy, 0);
    chk("R1", "done", done, 0);
    chk("R1", "rd_en", rd_en, 0);
    chk("R1", "wr_en", wr_en, 0);
    chk("R1", "csum", csum, 16'hFFFF);
  endtask

  task automatic t_header;
    run_check("R2", 0, 248, 252);
  endtask

  task automatic t_two_bytes;
    mem[300] = 8'h12; mem[301] = 8'h34; mem[302] = 8'h56;
    run_check("R3", 300, 2, 400);
  endtask

  task automatic t_odd;
    run_check("R4", 17, 7, 420);
    run_check("R4", 40, 1, 424);
  endtask

  task automatic t_zero;
    run_check("R5", 50, 0, 430);
    chk("R5", "zero count value", csum, 16'hFFFF);
  endtask

  task automatic t_overlap;
    for (int i = 0; i < 16; i++) mem[320+i] = 8'(i * 29 + 3);
    run_check("R3", 320, 16, 440);
    run_check("R3", 321, 15, 444);
  endtask

  task automatic t_busy_go;
    logic [15:0] exp;
    bit ok;
    exp = ref_sum(16, 20);
    mem[384] = 8'hA5; mem[385] = 8'h5A;
    launch(16, 20, 448);
    @(negedge clk);
    start_addr = AW'(0); byte_cnt = CW'(3); dest_addr = AW'(384);
    go = 1'b1;
    @(negedge clk);
    go = 1'b0;
    wait_done(ok);
    chk("R8", "completion", ok, 1);
    chk("R8", "csum unaffected", csum, exp);
    chk("R8", "guard byte 0", mem[384], 8'hA5);
    chk("R8", "guard byte 1", mem[385], 8'h5A);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R8", "stays idle", busy, 0);
    end
  endtask

  initial begin
    for (int i = 0; i < MS; i++) mem[i] = 8'((i * 37 + 11) & 8'hFF);
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    t_header;
    t_two_bytes;
    t_odd;
    t_zero;
    t_overlap;
    t_busy_go;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      nbad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end
endmodule